// File: doc/BRIEF.md
# Dual Control Register I2C Slave

This block is the serial control port of a two-channel supply controller. It listens to an I2C bus whose SCL and SDA have already been synchronised to the system clock. It pulls SDA low through an open-drain enable, and it holds the control bits that drive both channels. Each channel has an enable, a high-voltage select, a cable-drop compensation bit, a continuous-tone enable and a high-current-limit select. One dynamic current-limit mode bit is shared by the two channels.

A host writes one or more data bytes after the slave address. The top bit of each data byte chooses which of the two control banks the byte updates. Reads return a bank image in which the stored bits are combined with live status inputs: the per-channel overload flags and the over-temperature input. Losing power-good clears everything and makes the slave ignore the bus. Over-temperature clears the control bits but leaves the port able to answer, so the host can still read the cause.

Top module: `dual_ctl_i2c_slave`

## Requirements
- R1: After reset, every control output is 0 and `sda_oe_o` is 0 (SDA released).
- R2: The slave answers only to the 7-bit address 000100A, where A equals `addr_sel_i`, and bit 0 of the address byte is R/W (1 = read). A byte sent to any other address gets no ACK, and the slave stays silent until the next START.
- R3: A written data byte with bit 7 = 0 updates bank 0. Bank 0 bit 6 is the shared dynamic-limit bit. Bank 0 bits 5, 4, 3, 2 and 1 are channel 0's current select, tone enable, compensation, voltage select and enable.
- R4: A written data byte with bit 7 = 1 updates bank 1. Bank 1 bits 5 to 1 hold channel 1's fields in the same order as bank 0. Bits 6 and 0 of any written byte are ignored, and a write to one bank leaves the other bank unchanged.
- R5: The slave pulls SDA low for the whole ninth clock after a matching address byte and after each written data byte. It releases SDA after that clock.
- R6: Several data bytes in one write transaction are each decoded and applied in turn.
- R7: A read byte is sent MSB first. Bank 0 reads as {0, dynamic-limit, channel 0 fields, overload flag 0}. Bank 1 reads as {1, over-temperature, channel 1 fields, overload flag 1}. The flags are taken live when the byte is loaded.
- R8: A read starts with the bank most recently selected by a write, or bank 0 after a power-good loss. Each master ACK moves to the other bank for the next byte. A master NACK ends the read, and SDA stays released.
- R9: While `over_temp_i` is high, all writable bits are held at 0. Writes are still acknowledged but their data is discarded (the bank pointer still follows bit 7). Reads keep working.
- R10: While `pwr_ok_i` is low, both banks are held at 0, the bank pointer returns to bank 0, and the slave never pulls SDA.
- R11: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock |
| sda_i | input | 1 | Synchronised bus data (wired level) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 1 | Address LSB select |
| pwr_ok_i | input | 1 | Supply good; low clears and silences the port |
| over_temp_i | input | 1 | Over-temperature; high clears the control bits |
| ovl_flag_i | input | 2 | Live overload flag per channel |
| dyn_lim_o | output | 1 | Shared dynamic current-limit mode |
| ch_en_o | output | 2 | Per-channel enable |
| ch_vhi_o | output | 2 | Per-channel high-voltage select |
| ch_comp_o | output | 2 | Per-channel cable compensation |
| ch_tone_o | output | 2 | Per-channel continuous tone enable |
| ch_ihi_o | output | 2 | Per-channel high current-limit select |

## Verification
Two pairs of events can happen in the same clock cycle. The first pair is the commit of a written byte, on the falling SCL edge that ends its eighth bit, and the over-temperature clear. The bench holds `over_temp_i` high through a complete write, checks that the address and data are still acknowledged, and checks that every control output stays 0. The second pair is loading a read byte and a change on the live flag inputs. The flags are changed between transactions, and the bench checks that each byte, including the bank the master ACK switches to, carries the flag values present when it was loaded.

// File: rtl/dual_ctl_i2c_slave.sv
module dual_ctl_i2c_slave #(
  parameter logic [5:0] ADDR_HI = 6'b000100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       addr_sel_i,
  input  logic       pwr_ok_i,
  input  logic       over_temp_i,
  input  logic [1:0] ovl_flag_i,
  output logic       dyn_lim_o,
  output logic [1:0] ch_en_o,
  output logic [1:0] ch_vhi_o,
  output logic [1:0] ch_comp_o,
  output logic [1:0] ch_tone_o,
  output logic [1:0] ch_ihi_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACKA, S_WDAT, S_ACKW, S_RDAT, S_RACK, S_SKIP
  } st_t;

  st_t        st;
  logic       scl_q, sda_q;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [6:0] txb;
  logic       rd_sel, is_rd, m_ack;
  logic [6:1] bank0;
  logic [5:1] bank1;

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire addr_hit = (sh[7:1] == {ADDR_HI, addr_sel_i});
  wire byte_end = scl_fall && (cnt == 4'd8);
  wire wr_fire  = (st == S_WDAT) && byte_end;

  wire [7:0] rd_b0 = {1'b0, bank0, ovl_flag_i[0]};
  wire [7:0] rd_b1 = {1'b1, over_temp_i, bank1, ovl_flag_i[1]};
  wire [7:0] rd_cur = rd_sel ? rd_b1 : rd_b0;
  wire [7:0] rd_nxt = rd_sel ? rd_b0 : rd_b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank0 <= '0;
      bank1 <= '0;
    end else if (!pwr_ok_i || over_temp_i) begin
      bank0 <= '0;
      bank1 <= '0;
    end else if (wr_fire) begin
      if (sh[7]) bank1 <= sh[5:1];
      else       bank0 <= sh[6:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      cnt      <= '0;
      sh       <= '0;
      txb      <= '0;
      rd_sel   <= 1'b0;
      is_rd    <= 1'b0;
      m_ack    <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (!pwr_ok_i) begin
        st       <= S_IDLE;
        rd_sel   <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (start_c) begin
        st       <= S_ADDR;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_c) begin
        st       <= S_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (st)
          S_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_i};
              cnt <= cnt + 4'd1;
            end else if (byte_end) begin
              if (addr_hit) begin
                st       <= S_ACKA;
                is_rd    <= sh[0];
                sda_oe_o <= 1'b1;
              end else begin
                st <= S_SKIP;
              end
            end
          end
          S_ACKA: begin
            if (scl_fall) begin
              cnt <= '0;
              if (is_rd) begin
                st       <= S_RDAT;
                txb      <= rd_cur[6:0];
                sda_oe_o <= ~rd_cur[7];
              end else begin
                st       <= S_WDAT;
                sda_oe_o <= 1'b0;
              end
            end
          end
          S_WDAT: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_i};
              cnt <= cnt + 4'd1;
            end else if (byte_end) begin
              st       <= S_ACKW;
              rd_sel   <= sh[7];
              sda_oe_o <= 1'b1;
            end
          end
          S_ACKW: begin
            if (scl_fall) begin
              st       <= S_WDAT;
              cnt      <= '0;
              sda_oe_o <= 1'b0;
            end
          end
          S_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (byte_end) begin
              st       <= S_RACK;
              sda_oe_o <= 1'b0;
            end else if (scl_fall) begin
              sda_oe_o <= ~txb[6];
              txb      <= {txb[5:0], 1'b0};
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_i;
            end else if (scl_fall) begin
              if (m_ack) begin
                st       <= S_RDAT;
                cnt      <= '0;
                rd_sel   <= ~rd_sel;
                txb      <= rd_nxt[6:0];
                sda_oe_o <= ~rd_nxt[7];
              end else begin
                st <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign dyn_lim_o = bank0[6];
  assign ch_ihi_o  = {bank1[5], bank0[5]};
  assign ch_tone_o = {bank1[4], bank0[4]};
  assign ch_comp_o = {bank1[3], bank0[3]};
  assign ch_vhi_o  = {bank1[2], bank0[2]};
  assign ch_en_o   = {bank1[1], bank0[1]};

  a_r10_silent_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok_i |=> (!sda_oe_o && ch_en_o == 2'b00 && !dyn_lim_o && ch_vhi_o == 2'b00));

  a_r9_hot_clears_controls: assert property (@(posedge clk) disable iff (!rst_n)
    over_temp_i |=> ({dyn_lim_o, ch_en_o, ch_vhi_o, ch_comp_o, ch_tone_o, ch_ihi_o} == 11'd0));

  a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_i) && $past(pwr_ok_i) && !$past(start_c) && !$past(stop_c)) |-> $stable(sda_oe_o));

  a_r5_drive_in_slave_slots: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> (st == S_ACKA || st == S_ACKW || st == S_RDAT));

endmodule

// File: tb/dual_ctl_i2c_slave_tb.sv
module dual_ctl_i2c_slave_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic addr_sel = 1'b0, pwr_ok = 1'b0, over_temp = 1'b0;
  logic [1:0] ovl = 2'b00;
  logic sda_oe, dyn;
  logic [1:0] en, vhi, comp, tone, ihi;
  wire sda_bus = m_sda & ~sda_oe;

  dual_ctl_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .pwr_ok_i(pwr_ok), .over_temp_i(over_temp),
    .ovl_flag_i(ovl), .dyn_lim_o(dyn), .ch_en_o(en), .ch_vhi_o(vhi),
    .ch_comp_o(comp), .ch_tone_o(tone), .ch_ihi_o(ihi)
  );

  int checks = 0, fails = 0, viol = 0;

  typedef struct { logic [7:0] v; string tag; } item_t;
  item_t exp_q[$];
  logic [7:0] obs_q[$];

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_item(input logic [7:0] v, input string tag);
    item_t it;
    it.v = v; it.tag = tag;
    exp_q.push_back(it);
  endtask

  initial forever begin
    item_t e;
    logic [7:0] g;
    @(negedge clk);
    while (obs_q.size() > 0 && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      g = obs_q.pop_front();
      checks++;
      if (g !== e.v) begin
        fails++;
        $display("FAIL %s got=%02h exp=%02h", e.tag, g, e.v);
      end
    end
  end

  logic oe_p = 1'b0, scl_p = 1'b1;
  always @(negedge clk) begin
    if (rst_n && m_scl && scl_p && sda_oe !== oe_p) viol++;
    oe_p  <= sda_oe;
    scl_p <= m_scl;
  end

  task automatic chk_out(input logic [10:0] exp, input string tag);
    logic [10:0] got;
    @(negedge clk);
    got = {dyn, ihi, tone, comp, vhi, en};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s outputs got=%03h exp=%03h", tag, got, exp);
    end
    tick(1);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; tick(3);
    m_scl = 1'b1; tick(4);
    m_scl = 1'b0; tick(1);
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; tick(3);
    m_scl = 1'b1; tick(2);
    b = sda_bus; tick(2);
    m_scl = 1'b0; tick(1);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(2);
    m_scl = 1'b1; tick(3);
    m_sda = 1'b0; tick(3);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(2);
    m_scl = 1'b1; tick(3);
    m_sda = 1'b1; tick(3);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic a);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(!mack);
  endtask

  task automatic wr_tx(input logic [6:0] a, input int nb, input logic [7:0] d0,
                       input logic [7:0] d1, input logic hit, input string tag);
    logic ak;
    bus_start();
    expect_item({7'd0, !hit}, {tag, " address ack"});
    send_byte({a, 1'b0}, ak); obs_q.push_back({7'd0, ak});
    expect_item({7'd0, !hit}, {tag, " data0 ack"});
    send_byte(d0, ak); obs_q.push_back({7'd0, ak});
    if (nb > 1) begin
      expect_item({7'd0, !hit}, {tag, " data1 ack"});
      send_byte(d1, ak); obs_q.push_back({7'd0, ak});
    end
    bus_stop();
  endtask

  task automatic rd_tx(input logic [6:0] a, input int n, input logic [7:0] e0,
                       input logic [7:0] e1, input logic [7:0] e2, input string tag);
    logic ak;
    logic [7:0] v;
    logic [7:0] ex [3];
    ex[0] = e0; ex[1] = e1; ex[2] = e2;
    bus_start();
    expect_item(8'h00, {tag, " read address ack"});
    send_byte({a, 1'b1}, ak); obs_q.push_back({7'd0, ak});
    for (int k = 0; k < n; k++) begin
      expect_item(ex[k], {tag, " read byte"});
      recv_byte(v, k < n - 1);
      obs_q.push_back(v);
    end
    bus_stop();
  endtask

  task automatic run_all();
    rst_n = 1'b0; tick(4);
    rst_n = 1'b1; tick(2);
    chk_out(11'h000, "R1 reset controls");
    checks++;
    if (sda_oe !== 1'b0) begin fails++; $display("FAIL R1 sda_oe got=%b exp=0", sda_oe); end
    pwr_ok = 1'b1; tick(2);

    // R3 R5: bank0 write, bit0 ignored
    wr_tx(7'h08, 1, 8'h7E, 8'h00, 1'b1, "R3 R5 bank0 write");
    chk_out({1'b1, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01}, "R3 bank0 fields");
    // R4: bank1 write, bits 6/0 ignored, bank0 untouched
    wr_tx(7'h08, 1, 8'hFF, 8'h00, 1'b1, "R4 bank1 write");
    chk_out({1'b1, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11}, "R4 bank1 fields");
    // R2: wrong address ignored, data byte also unacked
    wr_tx(7'h09, 1, 8'h80, 8'h00, 1'b0, "R2 foreign address");
    chk_out({1'b1, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11}, "R2 foreign write ignored");
    addr_sel = 1'b1;
    wr_tx(7'h08, 1, 8'h80, 8'h00, 1'b0, "R2 old address after select");
    wr_tx(7'h09, 1, 8'h00, 8'h00, 1'b1, "R2 selected address");
    chk_out({1'b0, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10}, "R2 R3 bank0 cleared");
    // R7 R8: alternation with flags
    ovl = 2'b01;
    rd_tx(7'h09, 3, 8'h01, 8'hBE, 8'h01, "R7 R8 alternating");
    wr_tx(7'h09, 1, 8'h94, 8'h00, 1'b1, "R4 bank1 pattern");
    chk_out({1'b0, 2'b00, 2'b10, 2'b00, 2'b10, 2'b00}, "R4 bank1 pattern fields");
    rd_tx(7'h09, 1, 8'h94, 8'h00, 8'h00, "R8 starts at bank1");
    // R9: over temperature
    over_temp = 1'b1; tick(2);
    chk_out(11'h000, "R9 cleared by over temperature");
    wr_tx(7'h09, 1, 8'hFE, 8'h00, 1'b1, "R9 write while hot");
    chk_out(11'h000, "R9 hot write discarded");
    ovl = 2'b10;
    rd_tx(7'h09, 2, 8'hC1, 8'h00, 8'h00, "R9 R7 hot readback");
    over_temp = 1'b0; tick(2);
    // R6: two data bytes in one write
    wr_tx(7'h09, 2, 8'h06, 8'h88, 1'b1, "R6 streamed write");
    chk_out({1'b0, 2'b00, 2'b00, 2'b10, 2'b01, 2'b01}, "R6 both bytes applied");
    // R10: power-good loss
    pwr_ok = 1'b0; tick(2);
    chk_out(11'h000, "R10 cleared by power loss");
    wr_tx(7'h09, 1, 8'h7E, 8'h00, 1'b0, "R10 no ack unpowered");
    chk_out(11'h000, "R10 unpowered write ignored");
    pwr_ok = 1'b1; tick(2);
    chk_out(11'h000, "R10 still clear after restore");
    rd_tx(7'h09, 1, 8'h00, 8'h00, 8'h00, "R8 pointer back at bank0");
    tick(4);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard left=%0d exp=0", exp_q.size());
    end
    checks++;
    if (viol != 0) begin
      fails++;
      $display("FAIL R11 sda moves with scl high got=%0d exp=0", viol);
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired got=timeout exp=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule